// File: doc/BRIEF.md
# Host Word Read Transfer Counter

This block serves 16-bit reads by a host from a 16 KB byte-addressed sector buffer while a host-read transfer is open. It keeps a byte address counter and a remaining-byte counter. Each accepted read fetches one word from the buffer, moves the address on by two, takes two off the byte count, and closes the transfer when the count runs out.

A neighbouring register block opens a transfer with a one-cycle start pulse that carries the destination code and the two initial counter values. While the transfer is open, the host read strobe is only honoured if the active-low data-enable flag is low. The buffer is an external synchronous memory with one cycle of read latency. The word appears on the host data port one cycle after the accepted strobe, together with a valid pulse.

When the transfer completes, several things change on the same clock edge. The byte counter is reloaded to a marker value. The enable and busy flags go inactive. The end flag goes active. The mode byte records the end of the transfer. If both interrupt enables are set, a one-cycle interrupt request is raised.

Top module: `hwr_xfer_top`

## Requirements
- R1: After reset, `xfer_en_n`, `xfer_busy_n` and `end_flag_n` are 1, while `end_irq`, `host_valid`, `ctl_mode`, `addr_cnt` and `byte_cnt` are 0.
- R2: A start pulse loads `addr_cnt` and `byte_cnt` from the start values, drives `xfer_busy_n` to 0 and `end_flag_n` to 1, and sets `ctl_mode` to the destination code in bits 2:0 with bits 5:3 and 7 clear. Destination codes 2 and 3 are host reads: they drive `xfer_en_n` to 0 and set `ctl_mode` bit 6. Any other code leaves `xfer_en_n` at 1 and bit 6 clear.
- R3: A read strobe is ignored while `xfer_en_n` is 1, and also in a cycle that carries a start pulse. An ignored strobe produces no `host_valid`, issues no buffer read, and leaves both counters unchanged.
- R4: An accepted read issues one buffer read at address `addr_cnt` AND 0x3FFE (14 bits, so bit 0 is always 0).
- R5: One cycle after an accepted read, `host_valid` is 1 and `host_data` is {byte at the even address, byte at the odd address}. In all other cycles `host_valid` is 0.
- R6: Each accepted read adds 2 to `addr_cnt` and subtracts 2 from `byte_cnt`, both modulo 2^16.
- R7: The transfer ends on the accepted read whose decremented byte count, read as a signed 16-bit value, is at most 0. A start count of 0x8000 therefore takes 16384 reads.
- R8: At the end of a transfer, `byte_cnt` becomes 0xF000, `xfer_en_n` and `xfer_busy_n` become 1, and `end_flag_n` becomes 0. All of these change on the same edge.
- R9: `end_irq` is a one-cycle pulse on the edge where the transfer ends, raised only if `end_ie` and `lvl5_ie` are both 1.
- R10: At the end of a transfer, `ctl_mode` keeps bits 2:0, sets bit 7 and clears bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_start | input | 1 | One-cycle pulse that opens a transfer |
| start_dest | input | 3 | Destination code for the transfer |
| start_addr | input | 16 | Initial byte address |
| start_count | input | 16 | Initial byte count |
| host_rd | input | 1 | Host word read strobe |
| buf_even | input | 8 | Buffer byte at the even address, one cycle after the read |
| buf_odd | input | 8 | Buffer byte at the odd address, one cycle after the read |
| end_ie | input | 1 | Transfer-end interrupt enable |
| lvl5_ie | input | 1 | External level-5 interrupt enable |
| buf_rd_en | output | 1 | Buffer read request |
| buf_addr | output | 14 | Word-aligned buffer byte address |
| host_valid | output | 1 | Host word valid |
| host_data | output | 16 | Host word |
| xfer_en_n | output | 1 | Data-enable flag, active low |
| xfer_busy_n | output | 1 | Data-busy flag, active low |
| end_flag_n | output | 1 | Transfer-end flag, active low |
| end_irq | output | 1 | Level-5 interrupt request pulse |
| ctl_mode | output | 8 | Mode byte: destination, data ready (bit 6), end (bit 7) |
| addr_cnt | output | 16 | Current byte address counter |
| byte_cnt | output | 16 | Current byte counter |

## Verification
Every start count from 0 to 9 is swept for both host destinations and all four interrupt-enable pairs. This separates the signed "at most zero" end test from an unsigned test or an off-by-two test, and checks that both enables are needed for the interrupt. Reads are issued both back to back and spaced apart, which shows whether the one-cycle latency and the valid pulse line up in both cases. Start addresses that are odd, near the top of the 14-bit buffer, and at the 16-bit wrap check the masking and the counter wrap. One transfer starts at 0x8000, which is negative before its first read. It must run its full 16384 reads, which catches a sign test done on the value before the decrement. Non-host destinations, strobes after the end, and a start pulse in the same cycle as a strobe check that ignored reads leave the counters alone.

// File: rtl/hwr_pkg.sv
// Package: shared constants for the host word read transfer block.
// Assumes byte counters step by one 16-bit word (two bytes) per read.
package hwr_pkg;
    localparam int unsigned WORD_STEP   = 2;
    localparam int unsigned HOST_DEST_A = 2;
    localparam int unsigned HOST_DEST_B = 3;
endpackage

// File: rtl/hwr_addr_ctr.sv
// Byte address counter. It loads on a start pulse and moves on by one word for
// each accepted read. It also provides the word-aligned buffer address.
// Assumes load and step are never active together (the read path gates step).
module hwr_addr_ctr #(
    parameter int CNT_W  = 16,
    parameter int BUF_AW = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_val,
    input  logic              step,
    output logic [CNT_W-1:0]  cnt,
    output logic [BUF_AW-1:0] word_addr
);
    localparam logic [CNT_W-1:0] STEP_V = CNT_W'(hwr_pkg::WORD_STEP);

    // Address register: reset, load, or advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (step)
            cnt <= cnt + STEP_V;
    end

    // Buffer address: low buffer bits with bit 0 forced to zero.
    assign word_addr = {cnt[BUF_AW-1:1], 1'b0};
endmodule

// File: rtl/hwr_byte_ctr.sv
// Remaining-byte counter with signed end detection. It counts down by one
// word per read. When the decremented value is zero or negative it flags the
// end and reloads a marker value instead.
module hwr_byte_ctr #(
    parameter int               CNT_W  = 16,
    parameter logic [CNT_W-1:0] RELOAD = 16'hF000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic [CNT_W-1:0] cnt,
    output logic             done
);
    localparam logic [CNT_W-1:0] STEP_V = CNT_W'(hwr_pkg::WORD_STEP);

    logic [CNT_W-1:0] dec;

    // Decremented count and the signed "at most zero" test on it.
    always_comb begin
        dec  = cnt - STEP_V;
        done = step && (dec[CNT_W-1] || (dec == '0));
    end

    // Count register: reset, load, reload on end, or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (step)
            cnt <= done ? RELOAD : dec;
    end
endmodule

// File: rtl/hwr_read_path.sv
// Read acceptance and return path. It accepts a host strobe only while data
// enable is active and no start pulse is present. It issues the buffer read
// and marks the word valid one cycle later, when the synchronous buffer
// returns it.
module hwr_read_path #(
    parameter int BYTE_W = 8,
    parameter int BUF_AW = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_rd,
    input  logic                xfer_start,
    input  logic                xfer_en_n,
    input  logic [BUF_AW-1:0]   word_addr,
    input  logic [BYTE_W-1:0]   buf_even,
    input  logic [BYTE_W-1:0]   buf_odd,
    output logic                fire,
    output logic                buf_rd_en,
    output logic [BUF_AW-1:0]   buf_addr,
    output logic                host_valid,
    output logic [2*BYTE_W-1:0] host_data
);
    // Acceptance: the strobe counts only with enable active and no start.
    assign fire      = host_rd && !xfer_en_n && !xfer_start;
    assign buf_rd_en = fire;
    assign buf_addr  = word_addr;

    // Valid tracks the one-cycle buffer latency.
    always_ff @(posedge clk) begin
        if (!rst_n)
            host_valid <= 1'b0;
        else
            host_valid <= fire;
    end

    // Word assembly: the even byte goes in the upper half.
    assign host_data = host_valid ? {buf_even, buf_odd} : '0;
endmodule

// File: rtl/hwr_status.sv
// Status flags, mode byte and interrupt pulse. The start pulse opens a
// transfer. The end-of-transfer strobe updates every flag and the mode byte
// on one edge. Assumes MODE_W > DEST_W + 1, so the ready and end bits sit
// above the destination field.
module hwr_status #(
    parameter int DEST_W = 3,
    parameter int MODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DEST_W-1:0] start_dest,
    input  logic              done,
    input  logic              end_ie,
    input  logic              lvl5_ie,
    output logic              xfer_en_n,
    output logic              xfer_busy_n,
    output logic              end_flag_n,
    output logic              end_irq,
    output logic [MODE_W-1:0] ctl_mode
);
    localparam int END_BIT = MODE_W - 1;
    localparam int RDY_BIT = MODE_W - 2;

    logic              is_host;
    logic [MODE_W-1:0] mode_d;

    // Host-read destination decode.
    assign is_host = (start_dest == DEST_W'(hwr_pkg::HOST_DEST_A)) ||
                     (start_dest == DEST_W'(hwr_pkg::HOST_DEST_B));

    // Next mode byte: fresh on start, end marked on completion.
    always_comb begin
        mode_d = ctl_mode;
        if (start) begin
            mode_d                 = '0;
            mode_d[DEST_W-1:0]     = start_dest;
            mode_d[RDY_BIT]        = is_host;
        end else if (done) begin
            mode_d[END_BIT]        = 1'b1;
            mode_d[RDY_BIT]        = 1'b0;
        end
    end

    // Flag, mode and interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_en_n   <= 1'b1;
            xfer_busy_n <= 1'b1;
            end_flag_n  <= 1'b1;
            end_irq     <= 1'b0;
            ctl_mode    <= '0;
        end else begin
            ctl_mode <= mode_d;
            end_irq  <= 1'b0;
            if (start) begin
                xfer_en_n   <= !is_host;
                xfer_busy_n <= 1'b0;
                end_flag_n  <= 1'b1;
            end else if (done) begin
                xfer_en_n   <= 1'b1;
                xfer_busy_n <= 1'b1;
                end_flag_n  <= 1'b0;
                end_irq     <= end_ie && lvl5_ie;
            end
        end
    end
endmodule

// File: rtl/hwr_xfer_top.sv
// Host word read transfer counter, top level. Connects the address counter,
// the byte counter, the read path and the status logic. Assumes an external
// buffer that returns both bytes of a word one cycle after buf_rd_en.
module hwr_xfer_top #(
    parameter int               CNT_W      = 16,
    parameter int               BUF_AW     = 14,
    parameter int               BYTE_W     = 8,
    parameter int               DEST_W     = 3,
    parameter int               MODE_W     = 8,
    parameter logic [CNT_W-1:0] END_RELOAD = 16'hF000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                xfer_start,
    input  logic [DEST_W-1:0]   start_dest,
    input  logic [CNT_W-1:0]    start_addr,
    input  logic [CNT_W-1:0]    start_count,
    input  logic                host_rd,
    input  logic [BYTE_W-1:0]   buf_even,
    input  logic [BYTE_W-1:0]   buf_odd,
    input  logic                end_ie,
    input  logic                lvl5_ie,
    output logic                buf_rd_en,
    output logic [BUF_AW-1:0]   buf_addr,
    output logic                host_valid,
    output logic [2*BYTE_W-1:0] host_data,
    output logic                xfer_en_n,
    output logic                xfer_busy_n,
    output logic                end_flag_n,
    output logic                end_irq,
    output logic [MODE_W-1:0]   ctl_mode,
    output logic [CNT_W-1:0]    addr_cnt,
    output logic [CNT_W-1:0]    byte_cnt
);
    logic              fire;
    logic              done;
    logic [BUF_AW-1:0] word_addr;

    hwr_read_path #(.BYTE_W(BYTE_W), .BUF_AW(BUF_AW)) u_rd (
        .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .xfer_start(xfer_start),
        .xfer_en_n(xfer_en_n), .word_addr(word_addr), .buf_even(buf_even),
        .buf_odd(buf_odd), .fire(fire), .buf_rd_en(buf_rd_en),
        .buf_addr(buf_addr), .host_valid(host_valid), .host_data(host_data)
    );

    hwr_addr_ctr #(.CNT_W(CNT_W), .BUF_AW(BUF_AW)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(xfer_start), .load_val(start_addr),
        .step(fire), .cnt(addr_cnt), .word_addr(word_addr)
    );

    hwr_byte_ctr #(.CNT_W(CNT_W), .RELOAD(END_RELOAD)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(xfer_start), .load_val(start_count),
        .step(fire), .cnt(byte_cnt), .done(done)
    );

    hwr_status #(.DEST_W(DEST_W), .MODE_W(MODE_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .start(xfer_start), .start_dest(start_dest),
        .done(done), .end_ie(end_ie), .lvl5_ie(lvl5_ie), .xfer_en_n(xfer_en_n),
        .xfer_busy_n(xfer_busy_n), .end_flag_n(end_flag_n), .end_irq(end_irq),
        .ctl_mode(ctl_mode)
    );
endmodule

// File: rtl/hwr_xfer_chk.sv
// Checker for hwr_xfer_top. It relates the read path, the counters and the
// status flags over time. It is attached to every instance of the top by the
// bind at the end of this file.
module hwr_xfer_chk #(
    parameter int               CNT_W      = 16,
    parameter int               MODE_W     = 8,
    parameter logic [CNT_W-1:0] END_RELOAD = 16'hF000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xfer_start,
    input logic              end_ie,
    input logic              lvl5_ie,
    input logic              buf_rd_en,
    input logic              host_valid,
    input logic              xfer_en_n,
    input logic              xfer_busy_n,
    input logic              end_flag_n,
    input logic              end_irq,
    input logic [MODE_W-1:0] ctl_mode,
    input logic [CNT_W-1:0]  addr_cnt,
    input logic [CNT_W-1:0]  byte_cnt
);
    p_start_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> (!xfer_busy_n && end_flag_n));

    p_rd_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_en |-> (!xfer_en_n && !xfer_start));

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!buf_rd_en && !xfer_start) |=> ($stable(addr_cnt) && $stable(byte_cnt)));

    p_valid_after_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_en |=> host_valid);

    p_no_stray_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_rd_en |=> !host_valid);

    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd_en |=> (addr_cnt == CNT_W'($past(addr_cnt) + CNT_W'(2))));

    p_end_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(end_flag_n) |-> (xfer_en_n && xfer_busy_n && byte_cnt == END_RELOAD));

    p_irq_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        end_irq |-> $fell(end_flag_n));

    p_irq_enables_r9: assert property (@(posedge clk) disable iff (!rst_n)
        end_irq |-> ($past(end_ie) && $past(lvl5_ie)));

    p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        end_irq |=> !end_irq);

    p_mode_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(end_flag_n) |-> (ctl_mode[MODE_W-1] && !ctl_mode[MODE_W-2]));
endmodule

bind hwr_xfer_top hwr_xfer_chk #(
    .CNT_W(CNT_W), .MODE_W(MODE_W), .END_RELOAD(END_RELOAD)
) u_chk (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .end_ie(end_ie),
    .lvl5_ie(lvl5_ie), .buf_rd_en(buf_rd_en), .host_valid(host_valid),
    .xfer_en_n(xfer_en_n), .xfer_busy_n(xfer_busy_n), .end_flag_n(end_flag_n),
    .end_irq(end_irq), .ctl_mode(ctl_mode), .addr_cnt(addr_cnt),
    .byte_cnt(byte_cnt)
);

// File: tb/test_hwr_xfer_top.sv
module test_hwr_xfer_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_start = 1'b0;
    logic [2:0]  start_dest = '0;
    logic [15:0] start_addr = '0;
    logic [15:0] start_count = '0;
    logic        host_rd = 1'b0;
    logic [7:0]  buf_even = '0;
    logic [7:0]  buf_odd = '0;
    logic        end_ie = 1'b0;
    logic        lvl5_ie = 1'b0;
    logic        buf_rd_en;
    logic [13:0] buf_addr;
    logic        host_valid;
    logic [15:0] host_data;
    logic        xfer_en_n, xfer_busy_n, end_flag_n, end_irq;
    logic [7:0]  ctl_mode;
    logic [15:0] addr_cnt, byte_cnt;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    hwr_xfer_top i_hwr_xfer_top (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .start_dest(start_dest),
        .start_addr(start_addr), .start_count(start_count), .host_rd(host_rd),
        .buf_even(buf_even), .buf_odd(buf_odd), .end_ie(end_ie), .lvl5_ie(lvl5_ie),
        .buf_rd_en(buf_rd_en), .buf_addr(buf_addr), .host_valid(host_valid),
        .host_data(host_data), .xfer_en_n(xfer_en_n), .xfer_busy_n(xfer_busy_n),
        .end_flag_n(end_flag_n), .end_irq(end_irq), .ctl_mode(ctl_mode),
        .addr_cnt(addr_cnt), .byte_cnt(byte_cnt)
    );

    // Buffer content as a function of its byte address.
    function automatic logic [7:0] mem_byte(input logic [13:0] a);
        return a[7:0] ^ {a[13:8], 2'b10} ^ 8'h5A;
    endfunction

    // Synchronous buffer model with one cycle of latency.
    always_ff @(posedge clk) begin
        if (buf_rd_en) begin
            buf_even <= mem_byte({buf_addr[13:1], 1'b0});
            buf_odd  <= mem_byte({buf_addr[13:1], 1'b1});
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic open_xfer(input logic [2:0] dest, input logic [15:0] a0,
                             input logic [15:0] c0, input logic eie, input logic lie);
        @(negedge clk);
        xfer_start = 1'b1; start_dest = dest; start_addr = a0; start_count = c0;
        end_ie = eie; lvl5_ie = lie;
        @(posedge clk);
        @(negedge clk);
        xfer_start = 1'b0;
    endtask

    // Full host transfer with a reference model; hold=1 keeps the strobe high.
    task automatic run_xfer(input logic [2:0] dest, input logic [15:0] a0,
                            input logic [15:0] c0, input logic eie, input logic lie,
                            input bit hold, input int exp_reads);
        logic [15:0] e_addr, e_cnt, nd;
        logic [13:0] wa;
        logic [15:0] e_data;
        bit fin;
        int nrd;
        open_xfer(dest, a0, c0, eie, lie);
        chk("R2", "en_n after start", {31'd0, xfer_en_n}, 32'd0);
        chk("R2", "busy_n after start", {31'd0, xfer_busy_n}, 32'd0);
        chk("R2", "end_n after start", {31'd0, end_flag_n}, 32'd1);
        chk("R2", "mode after start", {24'd0, ctl_mode}, {24'd0, 8'h40 | {5'd0, dest}});
        chk("R2", "addr after start", {16'd0, addr_cnt}, {16'd0, a0});
        chk("R2", "count after start", {16'd0, byte_cnt}, {16'd0, c0});
        e_addr = a0; e_cnt = c0; fin = 1'b0; nrd = 0;
        while (!fin && nrd < 40000) begin
            wa = e_addr[13:0] & 14'h3FFE;
            e_data = {mem_byte(wa), mem_byte(wa | 14'h1)};
            host_rd = 1'b1;
            @(posedge clk);
            @(negedge clk);
            if (!hold) host_rd = 1'b0;
            e_addr = e_addr + 16'd2;
            nd = e_cnt - 16'd2;
            fin = ($signed(nd) <= 0);
            e_cnt = fin ? 16'hF000 : nd;
            nrd++;
            chk("R5", "valid", {31'd0, host_valid}, 32'd1);
            chk("R4", "word data", {16'd0, host_data}, {16'd0, e_data});
            chk("R6", "address", {16'd0, addr_cnt}, {16'd0, e_addr});
            chk("R6", "count", {16'd0, byte_cnt}, {16'd0, e_cnt});
            chk("R7", "en_n", {31'd0, xfer_en_n}, {31'd0, fin});
            chk("R7", "end_n", {31'd0, end_flag_n}, {31'd0, !fin});
            if (fin) begin
                chk("R8", "busy_n at end", {31'd0, xfer_busy_n}, 32'd1);
                chk("R9", "irq at end", {31'd0, end_irq}, {31'd0, eie & lie});
                chk("R10", "mode at end", {24'd0, ctl_mode}, {24'd0, 8'h80 | {5'd0, dest}});
            end else begin
                chk("R9", "irq mid", {31'd0, end_irq}, 32'd0);
                if (!hold) @(negedge clk);
            end
        end
        host_rd = 1'b0;
        chk("R7", "read count", nrd, exp_reads);
        @(posedge clk);
        @(negedge clk);
        chk("R9", "irq one cycle", {31'd0, end_irq}, 32'd0);
        chk("R5", "valid idle", {31'd0, host_valid}, 32'd0);
        host_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        host_rd = 1'b0;
        chk("R3", "valid after end", {31'd0, host_valid}, 32'd0);
        chk("R3", "address after end", {16'd0, addr_cnt}, {16'd0, e_addr});
        chk("R3", "count after end", {16'd0, byte_cnt}, 32'h0000F000);
        chk("R10", "mode held", {24'd0, ctl_mode}, {24'd0, 8'h80 | {5'd0, dest}});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", "en_n", {31'd0, xfer_en_n}, 32'd1);
        chk("R1", "busy_n", {31'd0, xfer_busy_n}, 32'd1);
        chk("R1", "end_n", {31'd0, end_flag_n}, 32'd1);
        chk("R1", "irq", {31'd0, end_irq}, 32'd0);
        chk("R1", "valid", {31'd0, host_valid}, 32'd0);
        chk("R1", "mode", {24'd0, ctl_mode}, 32'd0);
        chk("R1", "addr", {16'd0, addr_cnt}, 32'd0);
        chk("R1", "count", {16'd0, byte_cnt}, 32'd0);
        // R3 strobe before any transfer is ignored
        host_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        host_rd = 1'b0;
        chk("R3", "valid idle", {31'd0, host_valid}, 32'd0);
        chk("R3", "addr idle", {16'd0, addr_cnt}, 32'd0);

        // Sweep of start counts, destinations, enables and read spacing
        for (int d = 2; d <= 3; d++) begin
            for (int ie = 0; ie < 4; ie++) begin
                for (int c = 0; c < 10; c++) begin
                    logic [15:0] a0;
                    int er;
                    case (c % 4)
                        0: a0 = 16'h3FFF;
                        1: a0 = 16'hFFFC;
                        2: a0 = 16'(c * 16'h1235 + ie * 16'h0101);
                        default: a0 = 16'h3FFA;
                    endcase
                    er = (c == 0) ? 1 : (c + 1) / 2;
                    run_xfer(3'(d), a0, 16'(c), ie[1], ie[0], bit'((c + ie) % 2), er);
                end
            end
        end

        // R7 count that starts negative runs the long way round
        run_xfer(3'd3, 16'h0100, 16'h8000, 1'b1, 1'b1, 1'b1, 16384);

        // R2/R3 non-host destinations keep enable inactive and ignore reads
        for (int d = 0; d < 8; d++) begin
            if (d != 2 && d != 3) begin
                open_xfer(3'(d), 16'h0040, 16'h0010, 1'b1, 1'b1);
                chk("R2", "en_n non-host", {31'd0, xfer_en_n}, 32'd1);
                chk("R2", "busy_n non-host", {31'd0, xfer_busy_n}, 32'd0);
                chk("R2", "mode non-host", {24'd0, ctl_mode}, {29'd0, 3'(d)});
                host_rd = 1'b1;
                @(posedge clk);
                @(negedge clk);
                host_rd = 1'b0;
                chk("R3", "valid non-host", {31'd0, host_valid}, 32'd0);
                chk("R3", "addr non-host", {16'd0, addr_cnt}, 32'h00000040);
                chk("R3", "count non-host", {16'd0, byte_cnt}, 32'h00000010);
            end
        end

        // R3 start pulse in the same cycle as a strobe wins
        open_xfer(3'd2, 16'h0200, 16'h0064, 1'b0, 1'b0);
        @(negedge clk);
        xfer_start = 1'b1; start_dest = 3'd2; start_addr = 16'h0300; start_count = 16'h0020;
        host_rd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        xfer_start = 1'b0;
        host_rd = 1'b0;
        chk("R3", "addr on restart", {16'd0, addr_cnt}, 32'h00000300);
        chk("R3", "count on restart", {16'd0, byte_cnt}, 32'h00000020);
        @(posedge clk);
        @(negedge clk);
        chk("R3", "valid on restart", {31'd0, host_valid}, 32'd0);

        summary();
        $finish;
    end
endmodule